// File: doc/BRIEF.md
# Circular Free-Core Claim Arbiter

This block picks one core out of a group of cores to carry out a forwarded wakeup action for another core. Each core reports whether it is currently running in host mode. The block keeps a small action slot for each core, and a slot holding a nonzero code means that core is already busy with an earlier action.

A requester gives its own core index and a nonzero action code. In the same cycle the block scans the other cores in a circle. The scan starts just past the requester and wraps through index 0, and it never comes back to the requester. The block answers with the first core that is in host mode and whose slot is free. At the next clock edge it writes the action code into that core's slot, so the search and the claim act as one step.

When no core qualifies, the block reports a failure and leaves every slot as it was. The owner of a claimed slot frees it through a separate release input. The search order can be built either as a modular scan or as a split above/below mask, selected by a parameter.

Top module: `core_claim_arb`

## Requirements
- R1: After reset every action slot reads 0 (free), and grant_ok and grant_fail are both low while req_valid is low.
- R2: With req_valid high, the candidate order is req_core+1, req_core+2, …, NUM_CORES-1, then 0, 1, …, req_core-1. The first qualifying candidate in that order is returned on grant_core, with grant_ok high in the same cycle.
- R3: A core whose in_host bit is 0 never qualifies.
- R4: A core whose slot holds a nonzero code never qualifies, unless the same cycle releases that slot (see R9).
- R5: The requesting core itself is never granted, even when it is in host mode with a free slot.
- R6: On the clock edge that ends a granted request, the granted core's slot takes the value of req_action. slot_action packs slot i at bits [i*ACT_W +: ACT_W].
- R7: If no core qualifies, grant_fail is high, grant_ok is low, and no slot changes at the following edge.
- R8: A claimed slot keeps its code across later requests until a release names it. A release (rel_valid high, rel_core = index) clears that slot to 0 at the next edge.
- R9: When a release and a claim name the same slot in one cycle, the release is applied first. The slot counts as free for that cycle's search and holds the new code afterwards.
- R10: A request whose action code is 0 yields grant_fail and changes no slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_host | input | NUM_CORES | Per-core host-mode flag |
| req_valid | input | 1 | Claim request strobe |
| req_core | input | IDX_W | Requester's own core index |
| req_action | input | ACT_W | Action code to place in the claimed slot |
| rel_valid | input | 1 | Release strobe |
| rel_core | input | IDX_W | Slot to clear |
| grant_ok | output | 1 | A core was found and claimed this cycle |
| grant_fail | output | 1 | Request made but no core qualified |
| grant_core | output | IDX_W | Claimed core index (0 when none) |
| slot_action | output | NUM_CORES*ACT_W | Current contents of all action slots |

## Verification
The bench places the requester at different points in the ring, for example near the top so the search has to wrap, and checks the exact index granted. A design that scanned from 0 would return the wrong core. A design that started at the requester would grant the requester itself. The bench also marks slots busy or out of host mode and confirms they are skipped, and it fills the ring so that a failure must leave every slot untouched.

Two further cases target the edges of the rules. The first releases and claims the same slot in one cycle: a design that applied the claim before the release would report failure or end with a cleared slot. The second sends a zero action code, which must not mark any slot busy.

// File: rtl/claim_arb_pkg.sv
package claim_arb_pkg;
   // Structure used for the circular search.
   typedef enum logic [0:0] {
      SRCH_SCAN  = 1'b0,   // modular walk over offsets 1..N-1
      SRCH_SPLIT = 1'b1    // lowest-set-bit above start, else below start
   } srch_mode_e;
endpackage

// File: rtl/claim_search.sv
module claim_search
   import claim_arb_pkg::*;
#(
   parameter int         NUM_CORES = 8,
   parameter srch_mode_e MODE      = SRCH_SCAN,
   localparam int        IDX_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic [IDX_W-1:0]     start_idx,
   input  logic [NUM_CORES-1:0] elig,
   output logic                 found,
   output logic [IDX_W-1:0]     pick
);

   if (NUM_CORES < 2) begin : g_bad_n
      $error("claim_search: NUM_CORES must be at least 2");
   end

   if (MODE == SRCH_SCAN) begin : g_scan
      always_comb begin
         found = 1'b0;
         pick  = '0;
         for (int k = 1; k < NUM_CORES; k++) begin
            if (!found && elig[(int'(start_idx) + k) % NUM_CORES]) begin
               found = 1'b1;
               pick  = IDX_W'((int'(start_idx) + k) % NUM_CORES);
            end
         end
      end
   end else begin : g_split
      logic [NUM_CORES-1:0] above_m;
      logic [NUM_CORES-1:0] below_m;
      logic [NUM_CORES-1:0] hi_v;
      logic [NUM_CORES-1:0] lo_v;
      logic                 hi_f, lo_f;
      logic [IDX_W-1:0]     hi_i, lo_i;

      always_comb begin
         for (int i = 0; i < NUM_CORES; i++) begin
            above_m[i] = (i > int'(start_idx));
            below_m[i] = (i < int'(start_idx));
         end
         hi_v = elig & above_m;
         lo_v = elig & below_m;
      end

      always_comb begin
         hi_f = 1'b0;
         hi_i = '0;
         lo_f = 1'b0;
         lo_i = '0;
         for (int i = NUM_CORES - 1; i >= 0; i--) begin
            if (hi_v[i]) begin
               hi_f = 1'b1;
               hi_i = IDX_W'(i);
            end
            if (lo_v[i]) begin
               lo_f = 1'b1;
               lo_i = IDX_W'(i);
            end
         end
         found = hi_f | lo_f;
         pick  = hi_f ? hi_i : lo_i;
      end
   end

endmodule

// File: rtl/claim_slot_bank.sv
module claim_slot_bank #(
   parameter int  NUM_CORES = 8,
   parameter int  ACT_W     = 4,
   localparam int IDX_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                set_en,
   input  logic [IDX_W-1:0]                    set_idx,
   input  logic [ACT_W-1:0]                    set_val,
   input  logic                                clr_en,
   input  logic [IDX_W-1:0]                    clr_idx,
   output logic [NUM_CORES-1:0][ACT_W-1:0]     slots
);

   if (ACT_W < 1) begin : g_bad_w
      $error("claim_slot_bank: ACT_W must be at least 1");
   end

   for (genvar g = 0; g < NUM_CORES; g++) begin : g_slot
      logic hit_set, hit_clr;
      assign hit_set = set_en && (int'(set_idx) == g);
      assign hit_clr = clr_en && (int'(clr_idx) == g);

      // Release is applied first, so a same-cycle claim overrides it.
      always_ff @(posedge clk) begin
         if (!rst_n)       slots[g] <= '0;
         else if (hit_set) slots[g] <= set_val;
         else if (hit_clr) slots[g] <= '0;
      end

      p_busy_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
         ((slots[g] != '0) && !hit_clr && !hit_set) |=> $stable(slots[g]));

      p_claim_free_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
         hit_set |-> ((slots[g] == '0) || hit_clr));
   end

endmodule

// File: rtl/core_claim_arb.sv
module core_claim_arb
   import claim_arb_pkg::*;
#(
   parameter int         NUM_CORES = 8,
   parameter int         ACT_W     = 4,
   parameter srch_mode_e SRCH_MODE = SRCH_SCAN,
   localparam int        IDX_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_CORES-1:0]           in_host,
   input  logic                           req_valid,
   input  logic [IDX_W-1:0]               req_core,
   input  logic [ACT_W-1:0]               req_action,
   input  logic                           rel_valid,
   input  logic [IDX_W-1:0]               rel_core,
   output logic                           grant_ok,
   output logic                           grant_fail,
   output logic [IDX_W-1:0]               grant_core,
   output logic [NUM_CORES*ACT_W-1:0]     slot_action
);

   logic [NUM_CORES-1:0][ACT_W-1:0] slots;
   logic [NUM_CORES-1:0]            busy_now;
   logic [NUM_CORES-1:0]            rel_mask;
   logic [NUM_CORES-1:0]            elig;
   logic                            req_live;
   logic                            s_found;
   logic [IDX_W-1:0]                s_pick;

   always_comb begin
      for (int i = 0; i < NUM_CORES; i++) begin
         busy_now[i] = |slots[i];
         rel_mask[i] = rel_valid && (int'(rel_core) == i);
      end
   end

   assign elig     = in_host & ~(busy_now & ~rel_mask);
   assign req_live = req_valid && (req_action != '0);

   claim_search #(
      .NUM_CORES (NUM_CORES),
      .MODE      (SRCH_MODE)
   ) u_search (
      .start_idx (req_core),
      .elig      (elig),
      .found     (s_found),
      .pick      (s_pick)
   );

   assign grant_ok   = req_live && s_found;
   assign grant_fail = req_valid && !grant_ok;
   assign grant_core = grant_ok ? s_pick : '0;

   claim_slot_bank #(
      .NUM_CORES (NUM_CORES),
      .ACT_W     (ACT_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (grant_ok),
      .set_idx (s_pick),
      .set_val (req_action),
      .clr_en  (rel_valid),
      .clr_idx (rel_core),
      .slots   (slots)
   );

   assign slot_action = slots;

   p_not_self_r5: assert property (@(posedge clk) disable iff (!rst_n)
      grant_ok |-> (grant_core != req_core));

   p_host_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      grant_ok |-> in_host[grant_core]);

   p_claim_written_r6: assert property (@(posedge clk) disable iff (!rst_n)
      grant_ok |=> (slots[$past(grant_core)] == $past(req_action)));

   p_fail_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_fail && !rel_valid) |=> $stable(slots));

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (!grant_ok && !grant_fail));

   p_one_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({grant_ok, grant_fail}));

endmodule

// File: tb/sim_core_claim_arb.sv
module sim_core_claim_arb;
   localparam int N  = 8;
   localparam int AW = 4;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  in_host = '0;
   logic          req_valid = 1'b0;
   logic [IW-1:0] req_core = '0;
   logic [AW-1:0] req_action = '0;
   logic          rel_valid = 1'b0;
   logic [IW-1:0] rel_core = '0;
   logic          grant_ok, grant_fail;
   logic [IW-1:0] grant_core;
   logic [N*AW-1:0] slot_action;

   int total = 0;
   int bad   = 0;
   logic [N*AW-1:0] snap;

   always #4 clk = ~clk;

   core_claim_arb #(.NUM_CORES(N), .ACT_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .in_host(in_host),
      .req_valid(req_valid), .req_core(req_core), .req_action(req_action),
      .rel_valid(rel_valid), .rel_core(rel_core),
      .grant_ok(grant_ok), .grant_fail(grant_fail), .grant_core(grant_core),
      .slot_action(slot_action));

   task automatic chk(input string tag, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int slot(input int i);
      return int'(slot_action[i*AW +: AW]);
   endfunction

   // Request with optional same-cycle release; checks the combinational answer.
   task automatic do_req(input int core, input int act, input bit rel, input int rcore,
                         input bit exp_ok, input int exp_idx, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_core = IW'(core); req_action = AW'(act);
      rel_valid = rel;  rel_core = IW'(rcore);
      #1;
      chk({tag, " ok"},   grant_ok, exp_ok);
      chk({tag, " fail"}, grant_fail, !exp_ok);
      if (exp_ok) chk({tag, " idx"}, grant_core, exp_idx);
      @(posedge clk); #1;
      req_valid = 1'b0; rel_valid = 1'b0;
   endtask

   task automatic do_rel(input int core);
      @(negedge clk);
      rel_valid = 1'b1; rel_core = IW'(core);
      @(posedge clk); #1;
      rel_valid = 1'b0;
   endtask

   task automatic t_reset();
      #1;
      chk("R1 slots zero", slot_action, 0);
      chk("R1 idle ok", grant_ok, 0);
      chk("R1 idle fail", grant_fail, 0);
   endtask

   task automatic t_order();
      in_host = '1;
      do_req(5, 3, 0, 0, 1, 6, "R2 first after self");
      chk("R6 slot6 written", slot(6), 3);
      do_req(5, 2, 0, 0, 1, 7, "R4 skip busy 6");
      do_req(5, 4, 0, 0, 1, 0, "R2 wrap to 0");
      chk("R6 slot0 written", slot(0), 4);
      do_req(7, 1, 0, 0, 1, 1, "R2 wrap from top");
   endtask

   task automatic t_host();
      in_host = 8'b1111_1011;
      do_req(1, 5, 0, 0, 1, 3, "R3 skip non-host 2");
      chk("R6 slot3 written", slot(3), 5);
      chk("R8 slot6 held", slot(6), 3);
   endtask

   task automatic t_self();
      in_host = 8'b0001_0000;
      snap = slot_action;
      do_req(4, 6, 0, 0, 0, 0, "R5 self excluded");
      chk("R7 no change on fail", slot_action, snap);
   endtask

   task automatic t_full();
      in_host = '1;
      do_req(2, 7, 0, 0, 1, 4, "R2 fill 4");
      do_req(2, 7, 0, 0, 1, 5, "R2 fill 5");
      snap = slot_action;
      do_req(2, 8, 0, 0, 0, 0, "R7 ring full");
      chk("R7 full unchanged", slot_action, snap);
   endtask

   task automatic t_release();
      do_rel(6);
      chk("R8 slot6 cleared", slot(6), 0);
      chk("R8 slot7 kept", slot(7), 2);
      do_req(4, 9, 0, 0, 1, 6, "R8 freed slot reusable");
   endtask

   task automatic t_same_cycle();
      in_host = 8'b0000_1100;
      do_req(2, 11, 1, 3, 1, 3, "R9 release then claim");
      chk("R9 slot3 new code", slot(3), 11);
   endtask

   task automatic t_zero_code();
      do_rel(1);
      in_host = 8'b0000_0010;
      snap = slot_action;
      do_req(0, 0, 0, 0, 0, 0, "R10 zero code");
      chk("R10 no slot change", slot_action, snap);
      #1;
      chk("R1 idle after", grant_fail, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 t_reset();
      @(negedge clk) rst_n = 1'b1;
      t_order();
      t_host();
      t_self();
      t_full();
      t_release();
      t_same_cycle();
      t_zero_code();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule